// File: doc/BRIEF.md
# Dual-Channel ADC Serial Readout Controller

This block sits on the host side of a two-channel sampling converter that digitises both channels at the same instant. When the host asks for a sample, the controller drives a conversion-start pulse. It then waits for the converter's busy line to rise and fall again, and only after that opens a serial read. The read uses an active-low select and a serial clock that idles high. The converter presents the first bit when select falls and moves to each later bit on a rising clock edge. The controller samples each bit on the following falling edge, a half period later.

Two capture layouts are supported. In dual-lane mode both 16-bit results arrive together, one on each data line. In single-lane mode only the first line is used: channel A comes first and channel B follows, either in one long select frame or in two 16-clock frames. An optional status word can follow each result pair. A burst can also read several result pairs in one frame. In both of those cases select is held low for the whole frame. Each completed pair is presented on parallel outputs together with a one-cycle valid strobe. The serial clock rate comes from a programmable divider, and a minimum select-high time separates frames.

Top module: `dual_adc_reader`

## Requirements
- R1: After reset, select and serial clock are high, the conversion-start output is low and the valid strobe is low.
- R2: A start request in the idle state raises the conversion-start output for exactly CNV_CYC cycles (default 4). Start requests made during a conversion or a read, including one in the cycle the valid strobe is high, produce no further conversion-start pulse.
- R3: Select stays high while busy is high. A read frame opens only after busy has been seen high and has then returned low.
- R4: The serial clock is high whenever select is high. Bits are sampled on falling serial clock edges, most significant bit (bit 15) first.
- R5: In dual-lane mode (one_wire_i=0) a pair takes one 16-clock frame. Channel A is taken from sdo_a_i and channel B from sdo_b_i.
- R6: In single-lane mode (one_wire_i=1, split_i=0) a pair takes one 32-clock frame on sdo_a_i, channel A first and channel B second.
- R7: In single-lane mode with split_i=1, no status and a pair count of 1, the read uses two frames of 16 clocks each: channel A in the first and channel B in the second.
- R8: With status_en_i=1 each pair is followed by one more 16-bit word, taken from sdo_a_i and presented on res_stat_o. The frame grows by 16 clocks per pair.
- R9: A burst of pairs_i pairs (0 is read as 1, values above MAX_PAIRS as MAX_PAIRS) is read in a single frame. split_i has no effect when a status word is enabled or more than one pair is read.
- R10: res_valid_o is high for exactly one cycle per pair, and it comes with that pair's A, B and status words.
- R11: Between two frames of one read, select stays high for at least CSH_CYC cycles (default 3).
- R12: Each serial clock half period lasts clk_div_i system cycles, with 0 treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion and readout |
| one_wire_i | input | 1 | 1 = single-lane capture on sdo_a_i |
| split_i | input | 1 | Single-lane only: read A and B in separate frames |
| status_en_i | input | 1 | Append one status word to each pair |
| pairs_i | input | $clog2(MAX_PAIRS+1) | Result pairs per burst frame |
| clk_div_i | input | DIV_W | Serial clock half period in system cycles |
| busy_i | input | 1 | Converter busy indication |
| sdo_a_i | input | 1 | First serial data line |
| sdo_b_i | input | 1 | Second serial data line |
| cnv_o | output | 1 | Conversion-start pulse |
| cs_n_o | output | 1 | Active-low select |
| sclk_o | output | 1 | Serial clock, idle high |
| res_valid_o | output | 1 | One-cycle strobe for a finished pair |
| res_a_o | output | DATA_W | Channel A result |
| res_b_o | output | DATA_W | Channel B result |
| res_stat_o | output | DATA_W | Appended status word |

## Verification
Two events can fall in the same cycle. One is the result-valid strobe that closes a read. The other is a new start request, which the block must ignore because the frame has not yet been closed. The bench raises start in the very cycle it sees the strobe, and also once more while select is low. It then counts conversion-start rising edges over the whole run and expects exactly one, and it checks that the delivered words still match the converter model.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CNV,
    ST_BUSYH,
    ST_BUSYL,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } adcr_state_e;

  typedef struct packed {
    logic one_wire;
    logic split;
    logic stat;
  } adcr_cfg_t;
endpackage

// File: rtl/adcr_sync.sv
module adcr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adcr_tick.sv
module adcr_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d, lim;

  assign lim    = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick_o = en_i && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adcr_lane.sv
module adcr_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] word_o
);
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (smp_i) sh_d = {sh_q[DATA_W-2:0], din_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;
endmodule

// File: rtl/adcr_ctrl.sv
module adcr_ctrl
  import adcr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int MAX_PAIRS = 4,
  parameter int DIV_W     = 8,
  parameter int CNV_CYC   = 4,
  parameter int CSH_CYC   = 3,
  localparam int PAIR_W   = $clog2(MAX_PAIRS + 1),
  localparam int BIT_W    = $clog2(DATA_W),
  localparam int CNT_MAX  = (CNV_CYC > CSH_CYC) ? CNV_CYC : CSH_CYC,
  localparam int CNT_W    = $clog2(CNT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              one_wire_i,
  input  logic              split_i,
  input  logic              stat_i,
  input  logic [PAIR_W-1:0] pairs_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              busy_s_i,
  input  logic              tick_i,
  output logic              tick_en_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              cnv_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              smp_o,
  output logic              done_o,
  output logic [1:0]        done_pos_o,
  output logic              done_last_o,
  output logic              one_wire_o
);
  adcr_state_e       st_q, st_d;
  adcr_cfg_t         cfg_q, cfg_d;
  logic [PAIR_W-1:0] np_q, np_d, pair_q, pair_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [1:0]        wpos_q, wpos_d, wpp;
  logic              sclk_q, sclk_d, cs_q, cs_d, cnv_q, cnv_d;
  logic              end_q, end_d, all_q, all_d, smp;
  logic              done_q, done_d, dlast_q, dlast_d;
  logic [1:0]        dpos_q, dpos_d;
  logic              last_bit, last_word, last_pair, split_eff, launch;

  assign launch    = (st_q == ST_IDLE) && start_i;
  assign wpp       = 2'd1 + {1'b0, cfg_q.one_wire} + {1'b0, cfg_q.stat};
  assign last_bit  = (bit_q == BIT_W'(DATA_W - 1));
  assign last_word = (wpos_q == wpp - 2'd1);
  assign last_pair = (pair_q == np_q - PAIR_W'(1));
  assign split_eff = cfg_q.one_wire && cfg_q.split && !cfg_q.stat &&
                     (np_q == PAIR_W'(1));

  // state sequencing
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    smp    = 1'b0;
    case (st_q)
      ST_IDLE:  if (start_i) begin st_d = ST_CNV; cnt_d = '0; end
      ST_CNV:   if (cnt_q == CNT_W'(CNV_CYC - 1)) st_d = ST_BUSYH;
                else cnt_d = cnt_q + CNT_W'(1);
      ST_BUSYH: if (busy_s_i) st_d = ST_BUSYL;
      ST_BUSYL: if (!busy_s_i) st_d = ST_SHIFT;
      ST_SHIFT: if (tick_i) begin
                  if (sclk_q) begin
                    sclk_d = 1'b0;
                    smp    = 1'b1;
                  end else begin
                    sclk_d = 1'b1;
                    if (end_q) st_d = ST_TAIL;
                  end
                end
      ST_TAIL:  if (tick_i) begin st_d = ST_GAP; cnt_d = '0; end
      ST_GAP:   if (cnt_q == CNT_W'(CSH_CYC - 1)) st_d = all_q ? ST_IDLE : ST_SHIFT;
                else cnt_d = cnt_q + CNT_W'(1);
      default:  st_d = ST_IDLE;
    endcase
  end

  // configuration latch
  always_comb begin
    cfg_d = cfg_q;
    np_d  = np_q;
    div_d = div_q;
    if (launch) begin
      cfg_d.one_wire = one_wire_i;
      cfg_d.split    = split_i;
      cfg_d.stat     = stat_i;
      div_d          = div_i;
      if (pairs_i == '0)                       np_d = PAIR_W'(1);
      else if (pairs_i > PAIR_W'(MAX_PAIRS))   np_d = PAIR_W'(MAX_PAIRS);
      else                                     np_d = pairs_i;
    end
  end

  // bit, word and pair bookkeeping
  always_comb begin
    bit_d   = bit_q;
    wpos_d  = wpos_q;
    pair_d  = pair_q;
    end_d   = end_q;
    all_d   = all_q;
    done_d  = 1'b0;
    dpos_d  = dpos_q;
    dlast_d = dlast_q;
    if (launch) begin
      bit_d  = '0;
      wpos_d = '0;
      pair_d = '0;
      end_d  = 1'b0;
      all_d  = 1'b0;
    end else if (st_q == ST_TAIL) begin
      end_d = 1'b0;
    end else if (smp) begin
      bit_d = last_bit ? '0 : bit_q + BIT_W'(1);
      if (last_bit) begin
        done_d  = 1'b1;
        dpos_d  = wpos_q;
        dlast_d = last_word;
        end_d   = split_eff || (last_word && last_pair);
        all_d   = last_word && last_pair;
        if (last_word) begin
          wpos_d = '0;
          pair_d = pair_q + PAIR_W'(1);
        end else begin
          wpos_d = wpos_q + 2'd1;
        end
      end
    end
  end

  assign cnv_d = (st_d == ST_CNV);
  assign cs_d  = !((st_d == ST_SHIFT) || (st_d == ST_TAIL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cfg_q   <= '0;
      np_q    <= PAIR_W'(1);
      div_q   <= DIV_W'(1);
      cnt_q   <= '0;
      bit_q   <= '0;
      wpos_q  <= '0;
      pair_q  <= '0;
      sclk_q  <= 1'b1;
      cs_q    <= 1'b1;
      cnv_q   <= 1'b0;
      end_q   <= 1'b0;
      all_q   <= 1'b0;
      done_q  <= 1'b0;
      dpos_q  <= '0;
      dlast_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cfg_q   <= cfg_d;
      np_q    <= np_d;
      div_q   <= div_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      wpos_q  <= wpos_d;
      pair_q  <= pair_d;
      sclk_q  <= sclk_d;
      cs_q    <= cs_d;
      cnv_q   <= cnv_d;
      end_q   <= end_d;
      all_q   <= all_d;
      done_q  <= done_d;
      dpos_q  <= dpos_d;
      dlast_q <= dlast_d;
    end
  end

  assign tick_en_o   = (st_q == ST_SHIFT) || (st_q == ST_TAIL);
  assign div_o       = div_q;
  assign cnv_o       = cnv_q;
  assign cs_n_o      = cs_q;
  assign sclk_o      = sclk_q;
  assign smp_o       = smp;
  assign done_o      = done_q;
  assign done_pos_o  = dpos_q;
  assign done_last_o = dlast_q;
  assign one_wire_o  = cfg_q.one_wire;
endmodule

// File: rtl/adcr_collect.sv
module adcr_collect #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic [1:0]        pos_i,
  input  logic              last_i,
  input  logic              one_wire_i,
  input  logic [DATA_W-1:0] lane0_i,
  input  logic [DATA_W-1:0] lane1_i,
  output logic [DATA_W-1:0] a_o,
  output logic [DATA_W-1:0] b_o,
  output logic [DATA_W-1:0] stat_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d, s_q, s_d;
  logic              v_q, v_d;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    s_d = s_q;
    v_d = done_i && last_i;
    if (done_i) begin
      if (one_wire_i) begin
        case (pos_i)
          2'd0:    a_d = lane0_i;
          2'd1:    b_d = lane0_i;
          default: s_d = lane0_i;
        endcase
      end else if (pos_i == 2'd0) begin
        a_d = lane0_i;
        b_d = lane1_i;
      end else begin
        s_d = lane0_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      s_q <= '0;
      v_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      s_q <= s_d;
      v_q <= v_d;
    end
  end

  assign a_o     = a_q;
  assign b_o     = b_q;
  assign stat_o  = s_q;
  assign valid_o = v_q;
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DATA_W      = 16,
  parameter int MAX_PAIRS   = 4,
  parameter int DIV_W       = 8,
  parameter int CNV_CYC     = 4,
  parameter int CSH_CYC     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start_i,
  input  logic                           one_wire_i,
  input  logic                           split_i,
  input  logic                           status_en_i,
  input  logic [$clog2(MAX_PAIRS+1)-1:0] pairs_i,
  input  logic [DIV_W-1:0]               clk_div_i,
  input  logic                           busy_i,
  input  logic                           sdo_a_i,
  input  logic                           sdo_b_i,
  output logic                           cnv_o,
  output logic                           cs_n_o,
  output logic                           sclk_o,
  output logic                           res_valid_o,
  output logic [DATA_W-1:0]              res_a_o,
  output logic [DATA_W-1:0]              res_b_o,
  output logic [DATA_W-1:0]              res_stat_o
);
  localparam int LANES = 2;

  logic [1:0]        rst_chain_q;
  logic              rst_s_n, busy_s, tick, tick_en, smp;
  logic              done, done_last, ow;
  logic [1:0]        done_pos;
  logic [DIV_W-1:0]  div_cur;
  logic [LANES-1:0]  sdo;
  logic [DATA_W-1:0] lane_word [LANES];

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= 2'b00;
    else        rst_chain_q <= {rst_chain_q[0], 1'b1};
  end
  assign rst_s_n = rst_chain_q[1];

  adcr_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_busy_sync (
    .clk(clk), .rst_n(rst_s_n), .d_i(busy_i), .q_o(busy_s)
  );

  adcr_ctrl #(
    .DATA_W(DATA_W), .MAX_PAIRS(MAX_PAIRS), .DIV_W(DIV_W),
    .CNV_CYC(CNV_CYC), .CSH_CYC(CSH_CYC)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .start_i(start_i),
    .one_wire_i(one_wire_i), .split_i(split_i), .stat_i(status_en_i),
    .pairs_i(pairs_i), .div_i(clk_div_i), .busy_s_i(busy_s),
    .tick_i(tick), .tick_en_o(tick_en), .div_o(div_cur),
    .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .smp_o(smp),
    .done_o(done), .done_pos_o(done_pos), .done_last_o(done_last),
    .one_wire_o(ow)
  );

  adcr_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .en_i(tick_en), .div_i(div_cur), .tick_o(tick)
  );

  assign sdo = {sdo_b_i, sdo_a_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adcr_lane #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst_n(rst_s_n), .smp_i(smp), .din_i(sdo[g]),
      .word_o(lane_word[g])
    );
  end

  adcr_collect #(.DATA_W(DATA_W)) u_collect (
    .clk(clk), .rst_n(rst_s_n), .done_i(done), .pos_i(done_pos),
    .last_i(done_last), .one_wire_i(ow), .lane0_i(lane_word[0]),
    .lane1_i(lane_word[1]), .a_o(res_a_o), .b_o(res_b_o),
    .stat_o(res_stat_o), .valid_o(res_valid_o)
  );
endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
  parameter int CSH_CYC = 3
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_i,
  input logic cnv_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic res_valid_o
);
  logic [7:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= '0;
    else if (!cs_n_o)      hi_cnt <= '0;
    else if (hi_cnt != '1) hi_cnt <= hi_cnt + 8'd1;
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> sclk_o);

  assert_no_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> !busy_i);

  assert_cnv_outside_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_o |-> cs_n_o);

  assert_cnv_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_o) |-> $past(start_i));

  assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o |=> !res_valid_o);

  assert_cs_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_o) |-> (hi_cnt >= 8'(CSH_CYC)));
endmodule

bind dual_adc_reader adcr_checker #(.CSH_CYC(CSH_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_i(busy_i),
  .cnv_o(cnv_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .res_valid_o(res_valid_o)
);

// File: tb/sim_dual_adc_reader.sv
module sim_dual_adc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int CNV = 4;
  localparam int CSH = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start, ow, sp, st_en, busy;
  logic [2:0] pairs;
  logic [7:0] div;
  logic sdo_a, sdo_b;
  logic cnv, cs_n, sclk, vld;
  logic [15:0] ra, rb, rs;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_adc_reader u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .one_wire_i(ow),
    .split_i(sp), .status_en_i(st_en), .pairs_i(pairs), .clk_div_i(div),
    .busy_i(busy), .sdo_a_i(sdo_a), .sdo_b_i(sdo_b), .cnv_o(cnv),
    .cs_n_o(cs_n), .sclk_o(sclk), .res_valid_o(vld), .res_a_o(ra),
    .res_b_o(rb), .res_stat_o(rs)
  );

  // converter model
  logic [15:0] wa [8];
  logic [15:0] wb [8];
  logic [15:0] ws [8];
  logic m_ow, m_st;
  int   mdl_idx;

  function automatic logic lane_bit(input int lane, input int idx);
    int k = idx / 16;
    int b = 15 - (idx % 16);
    int wpp = (m_ow ? 2 : 1) + (m_st ? 1 : 0);
    int p = k / wpp;
    int pos = k % wpp;
    logic [15:0] w;
    if (p >= 8) return 1'b0;
    if (m_ow) w = (pos == 0) ? wa[p] : (pos == 1) ? wb[p] : ws[p];
    else      w = (pos == 0) ? ((lane == 0) ? wa[p] : wb[p]) : ws[p];
    return w[b];
  endfunction

  always @(posedge sclk or posedge cnv) begin
    if (cnv)        mdl_idx <= 0;
    else if (!cs_n) mdl_idx <= mdl_idx + 1;
  end

  always @(mdl_idx, cs_n) begin
    sdo_a = cs_n ? 1'b0 : lane_bit(0, mdl_idx);
    sdo_b = cs_n ? 1'b0 : lane_bit(1, mdl_idx);
  end

  initial busy = 1'b0;
  always @(posedge cnv) begin
    #(3*CLK_PERIOD);
    busy = 1'b1;
    #(20*CLK_PERIOD);
    busy = 1'b0;
  end

  // monitors
  logic [15:0] got_a [8];
  logic [15:0] got_b [8];
  logic [15:0] got_s [8];
  int nval, vwide, cnv_rises, cnv_w, cnv_run, frames, fcnt, gcnt, min_gap;
  int hp_cnt, hp_min, hp_max, busy_ovl;
  int fl [8];
  logic p_v, p_cnv, p_cs, p_sclk, hp_seen;

  task automatic clear_mon();
    nval = 0; vwide = 0; cnv_rises = 0; cnv_w = 0; cnv_run = 0;
    frames = 0; fcnt = 0; gcnt = 0; min_gap = 9999;
    hp_cnt = 0; hp_min = 9999; hp_max = 0; hp_seen = 1'b0; busy_ovl = 0;
    for (int i = 0; i < 8; i++) fl[i] = -1;
  endtask

  initial begin
    clear_mon();
    p_v = 1'b0; p_cnv = 1'b0; p_cs = 1'b1; p_sclk = 1'b1;
  end

  always @(negedge clk) begin
    if (vld) begin
      if (nval < 8) begin got_a[nval] = ra; got_b[nval] = rb; got_s[nval] = rs; end
      nval++;
      if (p_v) vwide++;
    end
    if (cnv) begin
      if (!p_cnv) cnv_rises++;
      cnv_run++;
    end else if (p_cnv) begin
      cnv_w = cnv_run;
      cnv_run = 0;
    end
    if (!cs_n && busy) busy_ovl++;
    if (p_cs && !cs_n) begin
      frames++;
      fcnt = 0;
      if (gcnt < min_gap) min_gap = gcnt;
    end
    if (!p_cs && cs_n && frames >= 1 && frames <= 8) fl[frames-1] = fcnt;
    if (cs_n) gcnt++; else gcnt = 0;
    if (p_sclk && !sclk && !cs_n) fcnt++;
    if (cs_n) begin
      hp_seen = 1'b0;
    end else if (sclk != p_sclk) begin
      if (hp_seen) begin
        if (hp_cnt < hp_min) hp_min = hp_cnt;
        if (hp_cnt > hp_max) hp_max = hp_cnt;
      end
      hp_cnt = 1;
      hp_seen = 1'b1;
    end else begin
      hp_cnt++;
    end
    p_v = vld; p_cnv = cnv; p_cs = cs_n; p_sclk = sclk;
  end

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; ow = 1'b0; sp = 1'b0; st_en = 1'b0;
    pairs = 3'd1; div = 8'd2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1, "R1 select idle high", int'(cs_n), 1);
    chk(sclk === 1'b1, "R1 sclk idle high", int'(sclk), 1);
    chk(cnv === 1'b0, "R1 conversion start low", int'(cnv), 0);
    chk(vld === 1'b0, "R1 valid low", int'(vld), 0);
  endtask

  task automatic run_conv(input logic c_ow, input logic c_sp, input logic c_st,
                          input int np, input int c_div, input int nfr,
                          input int nfl, input logic poke, input int seed,
                          input string tag);
    int npe = (np == 0) ? 1 : np;
    int de = (c_div == 0) ? 1 : c_div;
    int t = 0;
    @(negedge clk);
    ow = c_ow; sp = c_sp; st_en = c_st; pairs = 3'(np); div = 8'(c_div);
    m_ow = c_ow; m_st = c_st;
    for (int k = 0; k < 8; k++) begin
      wa[k] = 16'(32'h8001 + k * 32'h2B17 + seed * 32'h0911);
      wb[k] = 16'(32'h7FFE - k * 32'h1D35 + seed * 32'h0407);
      ws[k] = 16'(32'hA500 + k * 32'h0033 + seed);
    end
    if (seed == 2) begin wa[0] = 16'hFFFF; wb[0] = 16'h0000; end
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      while (cs_n && t < 20000) begin @(negedge clk); t++; end
      start = 1'b1; @(negedge clk); start = 1'b0;
      while (!vld && t < 20000) begin @(negedge clk); t++; end
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (nval < npe && t < 20000) begin @(negedge clk); t++; end
    repeat (40) @(negedge clk);
    chk(nval == npe, {tag, " R10 valid pulse count"}, nval, npe);
    for (int p = 0; p < npe && p < 8; p++) begin
      chk(got_a[p] == wa[p], {tag, " channel A word"}, int'(got_a[p]), int'(wa[p]));
      chk(got_b[p] == wb[p], {tag, " channel B word"}, int'(got_b[p]), int'(wb[p]));
      if (c_st)
        chk(got_s[p] == ws[p], {tag, " R8 status word"}, int'(got_s[p]), int'(ws[p]));
    end
    chk(frames == nfr, {tag, " frame count"}, frames, nfr);
    for (int f = 0; f < nfr && f < 8; f++)
      chk(fl[f] == nfl, {tag, " R4 falling edges per frame"}, fl[f], nfl);
    if (nfr > 1) chk(min_gap == CSH, {tag, " R11 select high gap"}, min_gap, CSH);
    chk(hp_min == de && hp_max == de, {tag, " R12 half period"}, hp_max, de);
    chk(busy_ovl == 0, {tag, " R3 frame during busy"}, busy_ovl, 0);
    chk(vwide == 0, {tag, " R10 valid wider than one cycle"}, vwide, 0);
    chk(cnv_rises == 1, {tag, " R2 conversion pulses"}, cnv_rises, 1);
    chk(cnv_w == CNV, {tag, " R2 conversion pulse width"}, cnv_w, CNV);
  endtask

  task automatic t_two_wire();     run_conv(0, 0, 0, 1, 2, 1, 16,  0, 1, "R5");        endtask
  task automatic t_edge_values();  run_conv(0, 0, 0, 1, 3, 1, 16,  0, 2, "R4 R5");     endtask
  task automatic t_one_wire();     run_conv(1, 0, 0, 1, 3, 1, 32,  0, 3, "R6");        endtask
  task automatic t_split();        run_conv(1, 1, 0, 1, 1, 2, 16,  0, 4, "R7 R11");    endtask
  task automatic t_status_two();   run_conv(0, 0, 1, 1, 2, 1, 32,  0, 5, "R8");        endtask
  task automatic t_status_split(); run_conv(1, 1, 1, 1, 2, 1, 48,  0, 6, "R8 R9");     endtask
  task automatic t_burst_two();    run_conv(0, 1, 0, 3, 1, 1, 48,  0, 7, "R9");        endtask
  task automatic t_burst_one();    run_conv(1, 1, 0, 2, 0, 1, 64,  0, 8, "R9 R12");    endtask
  task automatic t_burst_zero();   run_conv(0, 0, 0, 0, 1, 1, 16,  0, 9, "R9 zero");   endtask
  task automatic t_burst_stat();   run_conv(0, 0, 1, 4, 1, 1, 128, 0, 10, "R9 R10");   endtask
  task automatic t_ignore_start(); run_conv(0, 0, 0, 1, 2, 1, 16,  1, 11, "R2 R10");   endtask

  initial begin
    t_reset();
    t_two_wire();
    t_edge_values();
    t_one_wire();
    t_split();
    t_status_two();
    t_status_split();
    t_burst_two();
    t_burst_one();
    t_burst_zero();
    t_burst_stat();
    t_ignore_start();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule